// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Wake Filter

This block receives asynchronous serial frames that carry a ninth bit after the eight data bits. It oversamples the line sixteen times per bit, finds the start bit by a falling edge, and takes each bit at its middle. On a shared multi-drop line the ninth bit separates address frames from data frames. A station that is not addressed arms a wake filter. The filter then drops every data frame and lets no status flag move. When an address frame arrives, the filter stores it, records the ninth bit and disarms itself, so the data frames that follow are received as normal.

When the ninth bit is not used as an address marker, the block treats it as an even parity bit. In that mode the wake filter has no effect. Status flags stay set until the host clears them with a strobe. The receive interrupt and the error interrupt are derived from those flags and gated by an enable input.

Top module: `wake_rx_top`

## Requirements
- R1: A frame is received only while `rxEnable` is 1, and only after a falling edge on `rxIn` whose start bit is still low at its middle sample. While `rxEnable` is 0, nothing is received and any frame in progress is abandoned.
- R2: When `rxEnable` goes to 0, the flags `dataFull`, `frameErr`, `parErr` and `overrun` keep their values.
- R3: A frame is one low start bit, then eight data bits with the LSB first, then a ninth bit, then a stop bit. With `mpFormat`=0 the ninth bit is even parity over the data. If the nine bits hold an odd number of ones, `parErr` is set and the data is still stored.
- R4: With `mpFormat`=1 and `mpWakeArmed`=1, a frame whose ninth bit is 0 is discarded. `rxData`, `dataFull`, `frameErr`, `overrun` and `mpBit` all stay unchanged, even when the stop bit is low.
- R5: With `mpFormat`=1, a frame whose ninth bit is 1 is stored in `rxData`, sets `mpBit` to 1 and clears `mpWakeArmed`. The strobe `mpWakeArm` sets `mpWakeArmed` and `mpWakeDisarm` clears it.
- R6: After the wake-up of R5, frames with ninth bit 0 are stored and set `mpBit` to 0.
- R7: With `mpFormat`=0, `mpWakeArmed` filters nothing and keeps its value.
- R8: A stop bit sampled low sets `frameErr`.
- R9: If a frame completes while `dataFull` is 1, `overrun` is set and `rxData` keeps the older byte.
- R10: Each flag stays set until its clear strobe (`clrFull`, `clrFrameErr`, `clrParErr`, `clrOverrun`) is pulsed.
- R11: `rxIrq` = `rxIntEn` AND `dataFull`. `errIrq` = `rxIntEn` AND (`frameErr` OR `parErr` OR `overrun`).
- R12: The oversampling tick comes every `baudDiv`+1 clock cycles, and one bit lasts 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudDiv | input | DIV_W | Tick period minus one, in clock cycles |
| rxIn | input | 1 | Serial line, idle high |
| rxEnable | input | 1 | Receive enable |
| mpFormat | input | 1 | 1: ninth bit marks an address; 0: ninth bit is parity |
| mpWakeArm | input | 1 | Strobe that arms the wake filter |
| mpWakeDisarm | input | 1 | Strobe that disarms the wake filter |
| rxIntEn | input | 1 | Interrupt enable |
| clrFull | input | 1 | Clear strobe for dataFull |
| clrFrameErr | input | 1 | Clear strobe for frameErr |
| clrParErr | input | 1 | Clear strobe for parErr |
| clrOverrun | input | 1 | Clear strobe for overrun |
| rxData | output | DATA_W | Received data register |
| dataFull | output | 1 | Data register holds unread data |
| frameErr | output | 1 | Framing error flag |
| parErr | output | 1 | Parity error flag |
| overrun | output | 1 | Overrun flag |
| mpBit | output | 1 | Ninth bit of the last stored frame in address mode |
| mpWakeArmed | output | 1 | Wake filter state |
| rxIrq | output | 1 | Receive interrupt |
| errIrq | output | 1 | Error interrupt |

## Verification
The bench uses the default parameters: eight data bits and sixteen ticks per bit. It drives `baudDiv`=1, which makes one frame 352 cycles long, so dozens of frames fit into one run. Address, data, parity, framing and overrun cases are mixed in that run. One frame is also sent with `baudDiv`=3, which shows that bit timing follows the divider input and is not fixed.

// File: rtl/wake_rx_pkg.sv
package wake_rx_pkg;
  typedef struct packed {
    logic shiftEn;
    logic frameDone;
  } rxStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } rxState_t;
endpackage

// File: rtl/wake_rx_ctl.sv
module wake_rx_ctl
  import wake_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             rxEnable,
  input  logic             rxBit,
  input  logic             rxFall,
  output rxStrobes_t       strb,
  output logic             busy
);
  localparam int SCW = $clog2(OSR);
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int BCW = $clog2(FRAME_BITS + 1);
  localparam logic [SCW-1:0] MID  = SCW'(OSR / 2 - 1);
  localparam logic [SCW-1:0] LAST = SCW'(OSR - 1);
  localparam logic [BCW-1:0] BLAST = BCW'(FRAME_BITS - 1);

  rxState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [SCW-1:0]   sampCnt;
  logic [BCW-1:0]   bitCnt;
  logic             tick;

  assign tick = (divCnt >= baudDiv);
  assign busy = (state != ST_IDLE);

  always_comb begin
    strb.shiftEn   = rxEnable && state == ST_BITS && tick && sampCnt == LAST;
    strb.frameDone = rxEnable && state == ST_STOP && tick && sampCnt == LAST;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      sampCnt <= '0;
      bitCnt  <= '0;
    end else if (!rxEnable) begin
      state <= ST_IDLE;
    end else begin
      if (state == ST_IDLE) divCnt <= '0;
      else if (tick)        divCnt <= '0;
      else                  divCnt <= divCnt + 1'b1;

      unique case (state)
        ST_IDLE: if (rxFall) begin
          state   <= ST_START;
          sampCnt <= '0;
        end
        ST_START: if (tick) begin
          if (sampCnt == MID) begin
            sampCnt <= '0;
            bitCnt  <= '0;
            state   <= rxBit ? ST_IDLE : ST_BITS;
          end else sampCnt <= sampCnt + 1'b1;
        end
        ST_BITS: if (tick) begin
          sampCnt <= sampCnt + 1'b1;
          if (sampCnt == LAST) begin
            if (bitCnt == BLAST) state <= ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_STOP: if (tick) begin
          sampCnt <= sampCnt + 1'b1;
          if (sampCnt == LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wake_rx_dp.sv
module wake_rx_dp
  import wake_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  rxStrobes_t        strb,
  input  logic              mpFormat,
  input  logic              mpWakeArm,
  input  logic              mpWakeDisarm,
  input  logic              clrFull,
  input  logic              clrFrameErr,
  input  logic              clrParErr,
  input  logic              clrOverrun,
  output logic              rxBit,
  output logic              rxFall,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              frameErr,
  output logic              parErr,
  output logic              overrun,
  output logic              mpBit,
  output logic              mpWakeArmed
);
  localparam int SR_W = DATA_W + 1;

  logic            rxMeta, rxSync, rxPrev;
  logic [SR_W-1:0] shiftReg;
  logic            ninth, skip, accept, parBad;

  assign rxBit  = rxSync;
  assign rxFall = rxPrev & ~rxSync;
  assign ninth  = shiftReg[DATA_W];
  assign skip   = mpFormat && mpWakeArmed && !ninth;
  assign accept = strb.frameDone && !skip;
  assign parBad = ^shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {rxBit, shiftReg[SR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData      <= '0;
      dataFull    <= 1'b0;
      frameErr    <= 1'b0;
      parErr      <= 1'b0;
      overrun     <= 1'b0;
      mpBit       <= 1'b0;
      mpWakeArmed <= 1'b0;
    end else begin
      if (clrFull)     dataFull <= 1'b0;
      if (clrFrameErr) frameErr <= 1'b0;
      if (clrParErr)   parErr   <= 1'b0;
      if (clrOverrun)  overrun  <= 1'b0;
      if (mpWakeArm)    mpWakeArmed <= 1'b1;
      if (mpWakeDisarm) mpWakeArmed <= 1'b0;
      if (accept) begin
        if (dataFull) overrun <= 1'b1;
        else begin
          rxData   <= shiftReg[DATA_W-1:0];
          dataFull <= 1'b1;
        end
        if (!rxBit) frameErr <= 1'b1;
        if (!mpFormat && parBad) parErr <= 1'b1;
        if (mpFormat) begin
          mpBit <= ninth;
          if (ninth) mpWakeArmed <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wake_rx_top.sv
module wake_rx_top
  import wake_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              rxIn,
  input  logic              rxEnable,
  input  logic              mpFormat,
  input  logic              mpWakeArm,
  input  logic              mpWakeDisarm,
  input  logic              rxIntEn,
  input  logic              clrFull,
  input  logic              clrFrameErr,
  input  logic              clrParErr,
  input  logic              clrOverrun,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              frameErr,
  output logic              parErr,
  output logic              overrun,
  output logic              mpBit,
  output logic              mpWakeArmed,
  output logic              rxIrq,
  output logic              errIrq
);
  rxStrobes_t strb;
  logic       rxBit, rxFall, busy;

  wake_rx_ctl #(.DATA_W(DATA_W), .OSR(OSR), .DIV_W(DIV_W)) i_ctl (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .rxEnable(rxEnable),
    .rxBit(rxBit), .rxFall(rxFall), .strb(strb), .busy(busy)
  );

  wake_rx_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strb(strb),
    .mpFormat(mpFormat), .mpWakeArm(mpWakeArm), .mpWakeDisarm(mpWakeDisarm),
    .clrFull(clrFull), .clrFrameErr(clrFrameErr), .clrParErr(clrParErr),
    .clrOverrun(clrOverrun), .rxBit(rxBit), .rxFall(rxFall),
    .rxData(rxData), .dataFull(dataFull), .frameErr(frameErr),
    .parErr(parErr), .overrun(overrun), .mpBit(mpBit),
    .mpWakeArmed(mpWakeArmed)
  );

  assign rxIrq  = rxIntEn & dataFull;
  assign errIrq = rxIntEn & (frameErr | parErr | overrun);
endmodule

// File: rtl/wake_rx_chk.sv
module wake_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              busy,
  input logic              mpFormat,
  input logic              mpWakeDisarm,
  input logic              clrFull,
  input logic              clrFrameErr,
  input logic              clrParErr,
  input logic              clrOverrun,
  input logic [DATA_W-1:0] rxData,
  input logic              dataFull,
  input logic              frameErr,
  input logic              parErr,
  input logic              overrun,
  input logic              mpBit,
  input logic              mpWakeArmed
);
  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !busy);

  p_flags_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !clrFull && !clrFrameErr && !clrParErr && !clrOverrun)
    |=> $stable({dataFull, frameErr, parErr, overrun}));

  p_armed_stores_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mpFormat && mpWakeArmed && !clrFull && !dataFull) |=> (dataFull |-> mpBit));

  p_wake_sets_mpbit_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mpWakeArmed) && !$past(mpWakeDisarm)) |-> mpBit);

  p_keep_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataFull && !clrFull) |=> $stable(rxData));

  p_full_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dataFull && !clrFull) |=> dataFull);
endmodule

bind wake_rx_top wake_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .busy(busy),
  .mpFormat(mpFormat), .mpWakeDisarm(mpWakeDisarm), .clrFull(clrFull),
  .clrFrameErr(clrFrameErr), .clrParErr(clrParErr), .clrOverrun(clrOverrun),
  .rxData(rxData), .dataFull(dataFull), .frameErr(frameErr), .parErr(parErr),
  .overrun(overrun), .mpBit(mpBit), .mpWakeArmed(mpWakeArmed)
);

// File: tb/test_wake_rx_top.sv
module test_wake_rx_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baudDiv = 16'd1;
  logic        rxIn = 1'b1;
  logic        rxEnable = 1'b0, mpFormat = 1'b0, mpWakeArm = 1'b0, mpWakeDisarm = 1'b0;
  logic        rxIntEn = 1'b0;
  logic        clrFull = 1'b0, clrFrameErr = 1'b0, clrParErr = 1'b0, clrOverrun = 1'b0;
  logic [7:0]  rxData;
  logic        dataFull, frameErr, parErr, overrun, mpBit, mpWakeArmed, rxIrq, errIrq;
  int          vectors = 0;
  int          fails = 0;
  int          cycles = 0;

  always #5 clk = ~clk;

  wake_rx_top i_wake_rx_top (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .rxIn(rxIn), .rxEnable(rxEnable),
    .mpFormat(mpFormat), .mpWakeArm(mpWakeArm), .mpWakeDisarm(mpWakeDisarm),
    .rxIntEn(rxIntEn), .clrFull(clrFull), .clrFrameErr(clrFrameErr),
    .clrParErr(clrParErr), .clrOverrun(clrOverrun), .rxData(rxData),
    .dataFull(dataFull), .frameErr(frameErr), .parErr(parErr), .overrun(overrun),
    .mpBit(mpBit), .mpWakeArmed(mpWakeArmed), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(logic [7:0] d, logic ninth, logic stopBit);
    int bitCyc = 16 * (int'(baudDiv) + 1);
    logic [10:0] bits = {stopBit, ninth, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxIn = bits[i];
      repeat (bitCyc) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (2 * bitCyc) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearAll();
    clrFull = 1'b1; clrFrameErr = 1'b1; clrParErr = 1'b1; clrOverrun = 1'b1;
    @(negedge clk);
    clrFull = 1'b0; clrFrameErr = 1'b0; clrParErr = 1'b0; clrOverrun = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("reset dataFull", dataFull, 0);
    chk("reset flags", {frameErr, parErr, overrun, mpBit, mpWakeArmed}, 0);
    chk("reset irqs R11", {rxIrq, errIrq}, 0);
  endtask

  task automatic testDisabled();
    rxEnable = 1'b0;
    sendFrame(8'h5A, 1'b0, 1'b1);
    chk("R1 no reception while disabled", dataFull, 0);
    rxEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic testParity();
    sendFrame(8'hA5, 1'b0, 1'b1);
    chk("R3 data LSB first", rxData, 8'hA5);
    chk("R3 good parity", {dataFull, parErr}, 2'b10);
    rxIntEn = 1'b1;
    @(negedge clk);
    chk("R11 rxIrq", {rxIrq, errIrq}, 2'b10);
    pulse(clrFull);
    sendFrame(8'h3C, 1'b1, 1'b1);
    chk("R3 bad parity data kept", rxData, 8'h3C);
    chk("R3 parErr", parErr, 1);
    chk("R11 errIrq", errIrq, 1);
    rxIntEn = 1'b0;
    @(negedge clk);
    chk("R11 gated off", {rxIrq, errIrq}, 0);
    clearAll();
  endtask

  task automatic testFraming();
    sendFrame(8'h0F, 1'b0, 1'b0);
    chk("R8 frameErr", frameErr, 1);
    chk("R8 data stored", rxData, 8'h0F);
    repeat (500) @(negedge clk);
    chk("R10 flags sticky", {dataFull, frameErr}, 2'b11);
    pulse(clrFrameErr);
    chk("R10 clrFrameErr only", {dataFull, frameErr}, 2'b10);
    pulse(clrFull);
    chk("R10 clrFull", dataFull, 0);
  endtask

  task automatic testOverrun();
    sendFrame(8'h12, 1'b0, 1'b1);
    sendFrame(8'h34, 1'b1, 1'b1);
    chk("R9 overrun set", overrun, 1);
    chk("R9 old data kept", rxData, 8'h12);
    rxEnable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 flags kept after disable", {dataFull, overrun}, 2'b11);
    rxEnable = 1'b1;
    pulse(clrOverrun);
    chk("R10 clrOverrun", {dataFull, overrun}, 2'b10);
    clearAll();
  endtask

  task automatic testWake();
    mpFormat = 1'b1;
    pulse(mpWakeArm);
    chk("R5 arm strobe", mpWakeArmed, 1);
    sendFrame(8'h11, 1'b0, 1'b1);
    chk("R4 data frame skipped", {dataFull, mpWakeArmed}, 2'b01);
    sendFrame(8'h22, 1'b0, 1'b0);
    chk("R4 no frameErr on skipped", {frameErr, overrun, dataFull}, 0);
    sendFrame(8'h42, 1'b1, 1'b1);
    chk("R5 address stored", rxData, 8'h42);
    chk("R5 mpBit set, disarmed", {dataFull, mpBit, mpWakeArmed}, 3'b110);
    pulse(clrFull);
    sendFrame(8'h77, 1'b0, 1'b1);
    chk("R6 data after wake", rxData, 8'h77);
    chk("R6 mpBit cleared", {dataFull, mpBit}, 2'b10);
    pulse(clrFull);
    pulse(mpWakeArm);
    sendFrame(8'h99, 1'b0, 1'b1);
    chk("R4 rearmed skip", {dataFull, mpWakeArmed}, 2'b01);
    chk("R4 data reg untouched", rxData, 8'h77);
    mpFormat = 1'b0;
    sendFrame(8'h81, 1'b0, 1'b1);
    chk("R7 parity mode ignores filter", {rxData, dataFull, mpWakeArmed}, {8'h81, 2'b11});
    pulse(mpWakeDisarm);
    chk("R5 disarm strobe", mpWakeArmed, 0);
    clearAll();
  endtask

  task automatic testDivider();
    baudDiv = 16'd3;
    @(negedge clk);
    sendFrame(8'hC3, 1'b0, 1'b1);
    chk("R12 slower divider", {rxData, dataFull, parErr, frameErr}, {8'hC3, 3'b100});
    baudDiv = 16'd1;
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testParity();
    testFraming();
    testOverrun();
    testWake();
    testDivider();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule